// File: doc/BRIEF.md
# Serial Multi-Word Transmit Sequencer

This block sends a burst of four 16-bit words as one serial stream, most significant bit first. A host raises a start request while the sequencer is idle. The sequencer captures the first word from a parallel input and shifts the bits out on a data line, together with a serial clock. It fetches each following word from the same input at the word boundary, and a strobe tells the host when each word is taken.

A three-state transfer machine has three states: idle, transmitting and finished. When the bit counter reports that all 64 bits have gone out, the machine leaves the transmitting state. It then stays finished until the host releases the start request, so one request can never launch two bursts. A second, smaller machine counts word boundaries, but only while transmitting; outside that state it is held at zero. On the boundary of the fourth word it raises a one-cycle interrupt toward the host logic.

Each bit occupies two clock cycles. The serial clock is low in the first cycle of a bit and high in the second, and data changes only when the serial clock goes low.

Top module: `tx_burst_seq`

## Requirements
- R1: With the synchronous active-high reset `rst` asserted, the next clock edge leaves `idleFlag` high and `serData`, `serClk`, `wordIrq` and `wordTake` low. This holds both at power-up and in the middle of a burst.
- R2: When `startReq` is high in an idle cycle, `wordTake` is high in that same cycle. At the next edge `wordIn` is captured as the first word and transmission begins.
- R3: Bit k of a burst (k = 0 to 63) is driven on `serData` for two cycles. During the first of these `serClk` is 0; during the second `serClk` is 1. Within each word the bits go out MSB (bit 15) first. Outside transmission `serData` and `serClk` are 0.
- R4: `wordTake` is high during the second cycle of bit 15 of words 0, 1 and 2. At the following edge `wordIn` is captured as the next word. It is not high at the end of word 3.
- R5: After the 64th bit the sequencer leaves the transmitting state. The level of `startReq` during transmission has no effect on the burst.
- R6: In the finished state, a held `startReq` keeps the sequencer finished and starts no new burst. One edge after `startReq` goes low, the sequencer is idle again and can accept a new start.
- R7: `wordIrq` is high for exactly one cycle per burst: the second cycle of bit 63.
- R8: `idleFlag` is low exactly while transmitting and high in the idle and finished states.
- R9: The word counter is held at zero whenever `idleFlag` is high. Every burst, including the first burst after a reset that cut short an earlier burst, therefore raises `wordIrq` only after its fourth word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Burst start request |
| wordIn | input | 16 | Parallel word to be sent |
| serData | output | 1 | Serial data, MSB first |
| serClk | output | 1 | Serial bit clock |
| wordTake | output | 1 | wordIn is captured at the next edge |
| idleFlag | output | 1 | Low while transmitting |
| wordIrq | output | 1 | One-cycle interrupt after the fourth word |

## Verification
Three events fall on the same cycle: the word-counter interrupt, the length match that ends the transfer, and the fourth word boundary. All three happen in the second cycle of bit 63. Every burst provokes this, and the bench samples that exact cycle. It expects `wordIrq` high and `wordTake` low there, and expects `idleFlag` high one edge later. Bursts are run both with `startReq` held through the end and with it dropped early. This shows that the finish transition and the interrupt do not depend on the start level.

// File: rtl/tx_burst_seq_pkg.sv
package tx_burst_seq_pkg;

  // Transfer machine encoding; 2'b11 is unused and falls back to idle.
  typedef enum logic [1:0] {
    XF_IDLE = 2'b00,
    XF_SEND = 2'b01,
    XF_DONE = 2'b10
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture wordIn into the shifter
    logic run;    // transmitting: advance phase and bit counter
  } ctlStrobe_t;

  // Events from datapath to control
  typedef struct packed {
    logic wordMatch;  // last half of the last bit of a word
    logic lenMatch;   // last half of the last bit of the burst
  } dpEvent_t;

endpackage

// File: rtl/tx_burst_seq_dp.sv
module tx_burst_seq_dp
  import tx_burst_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serData,
  output logic              serClk,
  output dpEvent_t          evt
);

  localparam int TOTAL = WORD_W * WORDS;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(TOTAL);

  logic              phase;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] shiftReg;
  logic              bitEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (!ctl.run) begin
      phase  <= 1'b0;
      bitCnt <= '0;
      if (ctl.load) shiftReg <= wordIn;
    end else begin
      phase <= ~phase;
      if (phase) begin
        bitCnt <= bitCnt + 1'b1;
        if (ctl.load) shiftReg <= wordIn;
        else          shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign bitEnd        = ctl.run & phase;
  assign evt.wordMatch = bitEnd & (bitCnt[BIT_W-1:0] == {BIT_W{1'b1}});
  assign evt.lenMatch  = bitEnd & (bitCnt == CNT_W'(TOTAL - 1));
  assign serData       = ctl.run & shiftReg[WORD_W-1];
  assign serClk        = bitEnd;

  // R3: serial clock alternates every cycle while running
  a_r3_phase_alt: assert property (@(posedge clk) disable iff (rst)
    ctl.run && $past(ctl.run) |-> phase != $past(phase));

  // R4: a word boundary restarts the in-word bit position
  a_r4_word_wrap: assert property (@(posedge clk) disable iff (rst)
    evt.wordMatch && !evt.lenMatch |=> bitCnt[BIT_W-1:0] == '0);

  // R5: the length match only occurs on a word boundary
  a_r5_len_on_word: assert property (@(posedge clk) disable iff (rst)
    evt.lenMatch |-> evt.wordMatch);

endmodule

// File: rtl/tx_burst_seq_ctrl.sv
module tx_burst_seq_ctrl
  import tx_burst_seq_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  dpEvent_t   evt,
  output ctlStrobe_t ctl,
  output logic       idleFlag,
  output logic       wordIrq
);

  localparam int WCNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(WORDS - 1);

  xferState_t        state, stateNxt;
  logic [WCNT_W-1:0] wordCnt;
  logic              status;

  always_comb begin
    case (state)
      XF_IDLE: stateNxt = (startReq && !evt.lenMatch) ? XF_SEND : XF_IDLE;
      XF_SEND: stateNxt = evt.lenMatch ? XF_DONE : XF_SEND;
      XF_DONE: stateNxt = startReq ? XF_DONE : XF_IDLE;
      default: stateNxt = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= XF_IDLE;
    else     state <= stateNxt;
  end

  // Low only while sending
  assign status = (state != XF_SEND);

  // Word counter: cleared whenever the transfer status is high
  always_ff @(posedge clk) begin
    if (rst || status)          wordCnt <= '0;
    else if (evt.wordMatch)     wordCnt <= (wordCnt == LAST_WORD) ? '0 : wordCnt + 1'b1;
  end

  assign wordIrq  = !status && evt.wordMatch && (wordCnt == LAST_WORD);
  assign idleFlag = status;
  assign ctl.run  = !status;
  assign ctl.load = ((state == XF_IDLE) && startReq && !evt.lenMatch) ||
                    (!status && evt.wordMatch && !evt.lenMatch);

  // R5: the length match ends transmission
  a_r5_len_to_done: assert property (@(posedge clk) disable iff (rst)
    (state == XF_SEND) && evt.lenMatch |=> state == XF_DONE);

  // R6: a held start keeps the finished state
  a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
    (state == XF_DONE) && startReq |=> state == XF_DONE);

  // R7: interrupt lasts one cycle and coincides with the burst end
  a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
    wordIrq |=> !wordIrq);
  a_r7_irq_at_len: assert property (@(posedge clk) disable iff (rst)
    wordIrq |-> evt.lenMatch);

  // R9: counter is zero after any non-sending cycle
  a_r9_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
    status |=> wordCnt == '0);

endmodule

// File: rtl/tx_burst_seq.sv
module tx_burst_seq
  import tx_burst_seq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [WORD_W-1:0] wordIn,
  output logic              serData,
  output logic              serClk,
  output logic              wordTake,
  output logic              idleFlag,
  output logic              wordIrq
);

  ctlStrobe_t ctl;
  dpEvent_t   evt;

  tx_burst_seq_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .evt      (evt),
    .ctl      (ctl),
    .idleFlag (idleFlag),
    .wordIrq  (wordIrq)
  );

  tx_burst_seq_dp #(.WORD_W(WORD_W), .WORDS(WORDS)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .wordIn  (wordIn),
    .serData (serData),
    .serClk  (serClk),
    .evt     (evt)
  );

  assign wordTake = ctl.load;

endmodule

// File: tb/tx_burst_seq_bench.sv
module tx_burst_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [15:0] VEC_WORDS [0:NVEC-1] = '{
    16'hA5C3, 16'h0000, 16'hFFFF, 16'h8001,
    16'h1234, 16'hFEDC, 16'h5555, 16'hAAAA,
    16'h0F0F, 16'h7FFE, 16'hC001, 16'h3C3C
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [15:0] wordIn = '0;
  logic        serData, serClk, wordTake, idleFlag, wordIrq;

  int checks = 0;
  int errors = 0;

  tx_burst_seq u_tx_burst_seq (
    .clk(clk), .rst(rst), .startReq(startReq), .wordIn(wordIn),
    .serData(serData), .serClk(serClk), .wordTake(wordTake),
    .idleFlag(idleFlag), .wordIrq(wordIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkIdleOuts(input string req);
    check(req, {idleFlag, serData, serClk, wordIrq}, 4'b1000);
  endtask

  // One burst from table group b; optionally drop start right after launch
  task automatic runBurst(input int b, input bit holdStart);
    startReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b1;
    wordIn   = VEC_WORDS[4*b];
    #1;
    check("R2 take in idle", wordTake, 1'b1);
    @(posedge clk);
    for (int j = 0; j < 128; j++) begin
      @(negedge clk);
      if (!holdStart && j == 0) startReq = 1'b0;
      begin
        int bitIdx = j / 2;
        int w      = bitIdx / 16;
        int k      = bitIdx % 16;
        logic [15:0] cur = VEC_WORDS[4*b + w];
        logic expTake = (j % 2 == 1) && (k == 15) && (j < 127);
        check("R8 busy", idleFlag, 1'b0);
        check("R3 serClk", serClk, logic'(j % 2));
        check("R3 serData", serData, cur[15-k]);
        check("R4 wordTake", wordTake, expTake);
        check("R7 wordIrq", wordIrq, logic'(j == 127));
        if (expTake) wordIn = VEC_WORDS[4*b + w + 1];
      end
    end
    @(negedge clk);
    checkIdleOuts("R5 finished after 64 bits");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdleOuts("R1 reset");
    check("R1 take", wordTake, 1'b0);
    rst = 1'b0;

    // Table walk: each burst alternates held and dropped start (R5)
    for (int b = 0; b < 3; b++) runBurst(b, b[0]);

    // R6: finished state holds while start stays high
    runBurst(0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkIdleOuts("R6 no restart while held");
    end
    // release, then a fresh burst must launch (runBurst releases first)
    runBurst(1, 1'b0);

    // R1/R9: reset in the middle of a burst, then a full burst
    @(negedge clk);
    startReq = 1'b1;
    wordIn   = 16'hFFFF;
    repeat (40) @(negedge clk);
    check("R8 busy mid burst", idleFlag, 1'b0);
    rst = 1'b1;
    startReq = 1'b0;
    @(negedge clk);
    checkIdleOuts("R1 mid-burst reset");
    check("R1 take after reset", wordTake, 1'b0);
    rst = 1'b0;
    runBurst(2, 1'b0);
    check("R9 irq count after abort", wordIrq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule